// File: doc/BRIEF.md
# Dual-Channel IDE Card Host Decode and Interrupt Logic

This block is the bus-slave side of an expansion card that carries two IDE channels behind one byte-wide host bus. Every host read or write is decoded combinationally into one of a small set of windows: each channel's eight task-file registers, its control/alternate-status register, an interrupt mask port and an interrupt status port. There is also a slot select register and a four-location card identification readback. Task-file and control accesses become chip selects, a register index and read/write strobes toward the addressed IDE port. Read data from the drive is returned on the host bus.

Each channel keeps an interrupt enable. Any write to its mask port sets the enable, and reading that same port clears it. The drive's interrupt line passes through a two-stage synchroniser to form a pending flag. The card interrupt is raised while either channel has a pending flag together with its enable. A single DMA request/acknowledge pair from the card's one DMA engine is steered to one channel by bit 0 of the slot select register. The identification locations expose a 4-bit card type, one bit per location.

The host is expected to assert at most one of its read and write strobes in any cycle.

Top module: `dual_ide_card`

## Requirements
- R1: After reset both interrupt enables are clear, so the card interrupt stays low even with both drive interrupt lines high, and DMA acknowledge is routed to channel 1 (select bit 0).
- R2: Host address base+16*k for k in 0..7 (base 0x800 for channel 1, 0xC00 for channel 2) is task-file register k of that channel: on a read or write, that channel's task-file select bit (bit 0 = channel 1, bit 1 = channel 2) is high, the register index equals k, the matching strobe is high, and read data is that channel's drive data byte.
- R3: Address base+0xE0 is the channel's control/alternate-status register: it raises that channel's control select bit, drives register index 6, and returns that channel's drive data byte.
- R4: A write of any value to the mask port (base+0x80) sets that channel's interrupt enable.
- R5: A read of the mask port clears that channel's interrupt enable and returns 0x00.
- R6: A read of the status port (base+0xA4) returns the channel's pending flag in bit 0 and zero in bits 7..1. The flag equals the drive interrupt line delayed by two clock edges and is reported whatever the enable.
- R7: The card interrupt output is high exactly when some channel has both its pending flag and its enable set.
- R8: A write to address 0x000 latches data bit 0 as the DMA route; a read there returns the route in bit 0 with other bits zero; writing 0 restores the reset route.
- R9: The DMA request toward the engine is the selected channel's request. The engine's acknowledge reaches only the selected channel (route 0 = channel 1, route 1 = channel 2), and the other channel's acknowledge is held low.
- R10: Addresses 0x2280, 0x2284, 0x2288 and 0x228C return bits 0, 1, 2 and 3 of the card type parameter in data bit 0, with other bits zero.
- R11: Any other address reads 0xFF, raises no chip select or strobe, and a read or write there changes no enable and no route.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | 14 | Host byte address |
| host_rd | input | 1 | Host read strobe |
| host_wr | input | 1 | Host write strobe |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data |
| irq_out | output | 1 | Combined card interrupt |
| ide_cs_tf | output | 2 | Task-file select per channel |
| ide_cs_ctl | output | 2 | Control block select per channel |
| ide_reg | output | 3 | IDE register index |
| ide_rd | output | 1 | IDE read strobe |
| ide_wr | output | 1 | IDE write strobe |
| ide_wdata | output | 8 | Write data toward the drives |
| ide_rdata_in | input | 16 | Drive read data, channel 1 in bits 7..0, channel 2 in 15..8 |
| ide_intrq | input | 2 | Drive interrupt lines, one per channel |
| ide_dmarq | input | 2 | Drive DMA requests, one per channel |
| dma_req | output | 1 | DMA request toward the engine |
| dma_ack | input | 1 | DMA acknowledge from the engine |
| ide_dmack | output | 2 | DMA acknowledge per channel |

## Verification
Two functions can meet in one cycle. In the first, a mask-port read clears an enable on the same edge that the synchronised pending flag of that channel rises. The bench raises the drive interrupt line and issues the mask read exactly one cycle later, and it expects the card interrupt never to pulse. In the second, a slot select write changes the route while the engine's acknowledge is held high. There the acknowledge must move between channels on the following cycle, never reaching both. A behavioural model in the bench tracks enables, route and the two-edge interrupt delay. Every output is compared against it on each cycle, including during a long pseudo-random mix of accesses and interrupt activity.

// File: rtl/ics_pkg.sv
package ics_pkg;

    localparam int NCH         = 2;
    localparam int BYTE_W      = 8;
    localparam int TF_REGS     = 8;
    localparam int ID_BITS     = 4;
    localparam logic [2:0] CTL_REG_IDX = 3'd6;

    typedef enum logic [2:0] {
        RG_NONE,
        RG_TF,
        RG_CTL,
        RG_MASK,
        RG_STAT,
        RG_SEL,
        RG_ID
    } region_e;

    typedef struct packed {
        region_e    region;
        logic       ch;
        logic [2:0] idx;
    } dec_t;

endpackage

// File: rtl/ics_addr_decode.sv
module ics_addr_decode
    import ics_pkg::*;
#(
    parameter int                ADDR_W     = 14,
    parameter logic [ADDR_W-1:0] CH0_BASE   = 'h800,
    parameter logic [ADDR_W-1:0] CH1_BASE   = 'hC00,
    parameter int                STEP_SHIFT = 4,
    parameter logic [ADDR_W-1:0] MASK_OFF   = 'h80,
    parameter logic [ADDR_W-1:0] STAT_OFF   = 'hA4,
    parameter logic [ADDR_W-1:0] CTL_OFF    = 'hE0,
    parameter logic [ADDR_W-1:0] SEL_ADDR   = 'h000,
    parameter logic [ADDR_W-1:0] ID_BASE    = 'h2280,
    parameter int                ID_STRIDE  = 4
) (
    input  logic [ADDR_W-1:0] addr,
    output dec_t              dec
);

    localparam logic [ADDR_W-1:0] TF_SPAN = ADDR_W'(TF_REGS << STEP_SHIFT);
    localparam int                ID_SH   = $clog2(ID_STRIDE);
    localparam logic [ADDR_W-1:0] ID_SPAN = ADDR_W'(ID_BITS * ID_STRIDE);

    logic [ADDR_W-1:0] base [NCH];

    assign base[0] = CH0_BASE;
    assign base[1] = CH1_BASE;

    // Channel windows first, then the slot and identification locations.
    always_comb begin
        logic [ADDR_W-1:0] off;
        logic [ADDR_W-1:0] id_off;
        off    = '0;
        id_off = '0;
        dec    = '{region: RG_NONE, ch: 1'b0, idx: 3'd0};
        for (int c = 0; c < NCH; c++) begin
            off = addr - base[c];
            if (addr >= base[c]) begin
                if (off < TF_SPAN && off[STEP_SHIFT-1:0] == '0) begin
                    dec.region = RG_TF;
                    dec.ch     = 1'(c);
                    dec.idx    = off[STEP_SHIFT +: 3];
                end else if (off == CTL_OFF) begin
                    dec.region = RG_CTL;
                    dec.ch     = 1'(c);
                    dec.idx    = CTL_REG_IDX;
                end else if (off == MASK_OFF) begin
                    dec.region = RG_MASK;
                    dec.ch     = 1'(c);
                end else if (off == STAT_OFF) begin
                    dec.region = RG_STAT;
                    dec.ch     = 1'(c);
                end
            end
        end
        if (addr == SEL_ADDR) begin
            dec.region = RG_SEL;
        end
        id_off = addr - ID_BASE;
        if (addr >= ID_BASE && id_off < ID_SPAN && id_off[ID_SH-1:0] == '0) begin
            dec.region = RG_ID;
            dec.idx    = 3'(id_off >> ID_SH);
        end
    end

endmodule

// File: rtl/ics_chan_irq.sv
module ics_chan_irq #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic intrq,
    input  logic en_set,
    input  logic en_clr,
    output logic pend,
    output logic en
);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic                   en;
    } irq_st_t;

    irq_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[SYNC_STAGES-2:0], intrq};
        if (en_set) begin
            st_d.en = 1'b1;
        end else if (en_clr) begin
            st_d.en = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend = st_q.sync[SYNC_STAGES-1];
    assign en   = st_q.en;

endmodule

// File: rtl/ics_dma_route.sv
module ics_dma_route
    import ics_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           sel_wr,
    input  logic           sel_bit,
    input  logic [NCH-1:0] ide_dmarq,
    input  logic           dma_ack,
    output logic           dma_req,
    output logic [NCH-1:0] ide_dmack,
    output logic           sel
);

    typedef struct packed {
        logic sel;
    } route_st_t;

    route_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (sel_wr) begin
            st_d.sel = sel_bit;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sel     = st_q.sel;
    assign dma_req = ide_dmarq[st_q.sel];

    for (genvar c = 0; c < NCH; c++) begin : g_ack
        assign ide_dmack[c] = dma_ack && (st_q.sel == 1'(c));
    end

endmodule

// File: rtl/dual_ide_card.sv
module dual_ide_card
    import ics_pkg::*;
#(
    parameter int                ADDR_W      = 14,
    parameter logic [ADDR_W-1:0] CH0_BASE    = 'h800,
    parameter logic [ADDR_W-1:0] CH1_BASE    = 'hC00,
    parameter int                STEP_SHIFT  = 4,
    parameter logic [ADDR_W-1:0] MASK_OFF    = 'h80,
    parameter logic [ADDR_W-1:0] STAT_OFF    = 'hA4,
    parameter logic [ADDR_W-1:0] CTL_OFF     = 'hE0,
    parameter logic [ADDR_W-1:0] SEL_ADDR    = 'h000,
    parameter logic [ADDR_W-1:0] ID_BASE     = 'h2280,
    parameter int                ID_STRIDE   = 4,
    parameter logic [3:0]        CARD_TYPE   = 4'hF,
    parameter int                SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     host_addr,
    input  logic                  host_rd,
    input  logic                  host_wr,
    input  logic [7:0]            host_wdata,
    output logic [7:0]            host_rdata,
    output logic                  irq_out,
    output logic [1:0]            ide_cs_tf,
    output logic [1:0]            ide_cs_ctl,
    output logic [2:0]            ide_reg,
    output logic                  ide_rd,
    output logic                  ide_wr,
    output logic [7:0]            ide_wdata,
    input  logic [15:0]           ide_rdata_in,
    input  logic [1:0]            ide_intrq,
    input  logic [1:0]            ide_dmarq,
    output logic                  dma_req,
    input  logic                  dma_ack,
    output logic [1:0]            ide_dmack
);

    dec_t           dec;
    logic           access;
    logic           drive_hit;
    logic [NCH-1:0] chan_pend;
    logic [NCH-1:0] chan_en;
    logic           route_sel;

    ics_addr_decode #(
        .ADDR_W    (ADDR_W),
        .CH0_BASE  (CH0_BASE),
        .CH1_BASE  (CH1_BASE),
        .STEP_SHIFT(STEP_SHIFT),
        .MASK_OFF  (MASK_OFF),
        .STAT_OFF  (STAT_OFF),
        .CTL_OFF   (CTL_OFF),
        .SEL_ADDR  (SEL_ADDR),
        .ID_BASE   (ID_BASE),
        .ID_STRIDE (ID_STRIDE)
    ) u_dec (
        .addr(host_addr),
        .dec (dec)
    );

    assign access    = host_rd || host_wr;
    assign drive_hit = (dec.region == RG_TF) || (dec.region == RG_CTL);

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        logic hit_mask;
        assign hit_mask = (dec.region == RG_MASK) && (dec.ch == 1'(c));

        ics_chan_irq #(
            .SYNC_STAGES(SYNC_STAGES)
        ) u_irq (
            .clk   (clk),
            .rst_n (rst_n),
            .intrq (ide_intrq[c]),
            .en_set(host_wr && hit_mask),
            .en_clr(host_rd && !host_wr && hit_mask),
            .pend  (chan_pend[c]),
            .en    (chan_en[c])
        );

        assign ide_cs_tf[c]  = access && (dec.region == RG_TF)  && (dec.ch == 1'(c));
        assign ide_cs_ctl[c] = access && (dec.region == RG_CTL) && (dec.ch == 1'(c));
    end

    ics_dma_route u_route (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_wr   (host_wr && (dec.region == RG_SEL)),
        .sel_bit  (host_wdata[0]),
        .ide_dmarq(ide_dmarq),
        .dma_ack  (dma_ack),
        .dma_req  (dma_req),
        .ide_dmack(ide_dmack),
        .sel      (route_sel)
    );

    assign irq_out   = |(chan_pend & chan_en);
    assign ide_reg   = drive_hit ? dec.idx : 3'd0;
    assign ide_rd    = host_rd && drive_hit;
    assign ide_wr    = host_wr && drive_hit;
    assign ide_wdata = host_wdata;

    always_comb begin
        case (dec.region)
            RG_TF, RG_CTL: host_rdata = ide_rdata_in[{dec.ch, 3'b000} +: BYTE_W];
            RG_MASK:       host_rdata = 8'h00;
            RG_STAT:       host_rdata = {7'b0, chan_pend[dec.ch]};
            RG_SEL:        host_rdata = {7'b0, route_sel};
            RG_ID:         host_rdata = {7'b0, CARD_TYPE[dec.idx[1:0]]};
            default:       host_rdata = 8'hFF;
        endcase
    end

endmodule

// File: rtl/dual_ide_card_chk.sv
module dual_ide_card_chk #(
    parameter int                ADDR_W   = 14,
    parameter logic [ADDR_W-1:0] CH0_BASE = 'h800,
    parameter logic [ADDR_W-1:0] CH1_BASE = 'hC00,
    parameter logic [ADDR_W-1:0] MASK_OFF = 'h80,
    parameter logic [ADDR_W-1:0] STAT_OFF = 'hA4,
    parameter logic [ADDR_W-1:0] SEL_ADDR = 'h000
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] host_addr,
    input logic              host_rd,
    input logic              host_wr,
    input logic [7:0]        host_wdata,
    input logic [7:0]        host_rdata,
    input logic              irq_out,
    input logic [1:0]        ide_cs_tf,
    input logic [1:0]        ide_cs_ctl,
    input logic [1:0]        ide_dmack,
    input logic [1:0]        chan_en,
    input logic              route_sel
);

    localparam logic [ADDR_W-1:0] MASK0 = CH0_BASE + MASK_OFF;
    localparam logic [ADDR_W-1:0] MASK1 = CH1_BASE + MASK_OFF;
    localparam logic [ADDR_W-1:0] STAT0 = CH0_BASE + STAT_OFF;

    logic low_gap;
    assign low_gap = (host_addr > SEL_ADDR) && (host_addr < CH0_BASE);

    assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (chan_en == 2'b00) && !route_sel);

    assert_mask_set_ch0_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr == MASK0) |=> chan_en[0]);

    assert_mask_set_ch1_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr == MASK1) |=> chan_en[1]);

    assert_mask_clr_ch0_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && !host_wr && host_addr == MASK0) |=> !chan_en[0]);

    assert_stat_upper_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (host_addr == STAT0) |-> (host_rdata[7:1] == 7'd0));

    assert_irq_masked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_en == 2'b00) |-> !irq_out);

    assert_sel_latch_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr == SEL_ADDR) |=> (route_sel == $past(host_wdata[0])));

    assert_ack_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ide_dmack));

    assert_ack_unselected_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !ide_dmack[~route_sel]);

    assert_gap_reads_ff_R11: assert property (@(posedge clk) disable iff (!rst_n)
        low_gap |-> (host_rdata == 8'hFF) && (ide_cs_tf == 2'b00) && (ide_cs_ctl == 2'b00));

    assert_gap_no_effect_R11: assert property (@(posedge clk) disable iff (!rst_n)
        low_gap |=> (chan_en == $past(chan_en)) && (route_sel == $past(route_sel)));

endmodule

bind dual_ide_card dual_ide_card_chk #(
    .ADDR_W  (ADDR_W),
    .CH0_BASE(CH0_BASE),
    .CH1_BASE(CH1_BASE),
    .MASK_OFF(MASK_OFF),
    .STAT_OFF(STAT_OFF),
    .SEL_ADDR(SEL_ADDR)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .host_addr (host_addr),
    .host_rd   (host_rd),
    .host_wr   (host_wr),
    .host_wdata(host_wdata),
    .host_rdata(host_rdata),
    .irq_out   (irq_out),
    .ide_cs_tf (ide_cs_tf),
    .ide_cs_ctl(ide_cs_ctl),
    .ide_dmack (ide_dmack),
    .chan_en   (chan_en),
    .route_sel (route_sel)
);

// File: tb/test_dual_ide_card.sv
module test_dual_ide_card;

    localparam logic [3:0] TYPE_CODE = 4'b1101;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [13:0] host_addr = 14'h100;
    logic        host_rd = 1'b0;
    logic        host_wr = 1'b0;
    logic [7:0]  host_wdata = 8'h00;
    logic [7:0]  host_rdata;
    logic        irq_out;
    logic [1:0]  ide_cs_tf;
    logic [1:0]  ide_cs_ctl;
    logic [2:0]  ide_reg;
    logic        ide_rd;
    logic        ide_wr;
    logic [7:0]  ide_wdata;
    logic [15:0] ide_rdata_in = 16'hC35A;
    logic [1:0]  ide_intrq = 2'b00;
    logic [1:0]  ide_dmarq = 2'b00;
    logic        dma_req;
    logic        dma_ack = 1'b0;
    logic [1:0]  ide_dmack;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // behavioural model state
    bit [1:0] m_en;
    bit       m_sel;
    bit [1:0] m_p1;
    bit [1:0] m_p2;

    always #5 clk = ~clk;

    dual_ide_card #(.CARD_TYPE(TYPE_CODE)) i_dual_ide_card (
        .clk         (clk),
        .rst_n       (rst_n),
        .host_addr   (host_addr),
        .host_rd     (host_rd),
        .host_wr     (host_wr),
        .host_wdata  (host_wdata),
        .host_rdata  (host_rdata),
        .irq_out     (irq_out),
        .ide_cs_tf   (ide_cs_tf),
        .ide_cs_ctl  (ide_cs_ctl),
        .ide_reg     (ide_reg),
        .ide_rd      (ide_rd),
        .ide_wr      (ide_wr),
        .ide_wdata   (ide_wdata),
        .ide_rdata_in(ide_rdata_in),
        .ide_intrq   (ide_intrq),
        .ide_dmarq   (ide_dmarq),
        .dma_req     (dma_req),
        .dma_ack     (dma_ack),
        .ide_dmack   (ide_dmack)
    );

    // kind: 0 none, 1 task file, 2 control, 3 mask, 4 status, 5 select, 6 ident
    task automatic classify(input logic [13:0] a, output int kind, output int ch, output int idx);
        int ai;
        ai   = int'(a);
        kind = 0;
        ch   = 0;
        idx  = 0;
        for (int c = 0; c < 2; c++) begin
            int b;
            b = (c == 0) ? 'h800 : 'hC00;
            if (ai >= b && ai < b + 'h80 && (ai % 16) == 0) begin
                kind = 1; ch = c; idx = (ai - b) / 16;
            end else if (ai == b + 'hE0) begin
                kind = 2; ch = c; idx = 6;
            end else if (ai == b + 'h80) begin
                kind = 3; ch = c;
            end else if (ai == b + 'hA4) begin
                kind = 4; ch = c;
            end
        end
        if (ai == 0) kind = 5;
        if (ai >= 'h2280 && ai < 'h2290 && (ai % 4) == 0) begin
            kind = 6; idx = (ai - 'h2280) / 4;
        end
    endtask

    always @(posedge clk or negedge rst_n) begin : model
        int k, c, x;
        if (!rst_n) begin
            m_en  = 2'b00;
            m_sel = 1'b0;
            m_p1  = 2'b00;
            m_p2  = 2'b00;
        end else begin
            classify(host_addr, k, c, x);
            m_p2 = m_p1;
            m_p1 = ide_intrq;
            if (host_wr && k == 3) m_en[c] = 1'b1;
            if (host_rd && !host_wr && k == 3) m_en[c] = 1'b0;
            if (host_wr && k == 5) m_sel = host_wdata[0];
        end
    end

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h (t=%0t)", req, got, exp, $time);
        end
    endtask

    task automatic compare_all();
        int k, c, x;
        logic [7:0] exp_rd;
        string lab;
        classify(host_addr, k, c, x);
        check("R7 card interrupt", 32'(irq_out), 32'((m_en[0] & m_p2[0]) | (m_en[1] & m_p2[1])));
        check("R9 dma request", 32'(dma_req), 32'(ide_dmarq[m_sel]));
        check("R9 dma acknowledge", 32'(ide_dmack), dma_ack ? (m_sel ? 32'd2 : 32'd1) : 32'd0);
        case (k)
            1: begin lab = "R2 task-file";  exp_rd = ide_rdata_in[c*8 +: 8]; end
            2: begin lab = "R3 control";    exp_rd = ide_rdata_in[c*8 +: 8]; end
            3: begin lab = "R5 mask port";  exp_rd = 8'h00; end
            4: begin lab = "R6 status";     exp_rd = {7'b0, m_p2[c]}; end
            5: begin lab = "R8 select";     exp_rd = {7'b0, m_sel}; end
            6: begin lab = "R10 ident";     exp_rd = {7'b0, TYPE_CODE[x]}; end
            default: begin lab = "R11 undecoded"; exp_rd = 8'hFF; end
        endcase
        check(lab, 32'(host_rdata), 32'(exp_rd));
        check(lab, 32'(ide_cs_tf), (k == 1 && (host_rd || host_wr)) ? (32'd1 << c) : 32'd0);
        check(lab, 32'(ide_cs_ctl), (k == 2 && (host_rd || host_wr)) ? (32'd1 << c) : 32'd0);
        check(lab, 32'(ide_rd), 32'(host_rd && (k == 1 || k == 2)));
        check(lab, 32'(ide_wr), 32'(host_wr && (k == 1 || k == 2)));
        if (k == 1 || k == 2) check(lab, 32'(ide_reg), 32'(x));
        if (host_wr && k == 1) check("R2 write data", 32'(ide_wdata), 32'(host_wdata));
    endtask

    task automatic drive(input logic [13:0] a, input logic rd, input logic wr, input logic [7:0] wd);
        @(negedge clk);
        if (rst_n) compare_all();
        host_addr  = a;
        host_rd    = rd;
        host_wr    = wr;
        host_wdata = wd;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive(14'h100, 1'b0, 1'b0, 8'h00);
    endtask

    function automatic logic [13:0] pick(input logic [3:0] i);
        case (i)
            4'd0:  pick = 14'h800;
            4'd1:  pick = 14'h870;
            4'd2:  pick = 14'h880;
            4'd3:  pick = 14'h8A4;
            4'd4:  pick = 14'h8E0;
            4'd5:  pick = 14'hC30;
            4'd6:  pick = 14'hC80;
            4'd7:  pick = 14'hCA4;
            4'd8:  pick = 14'hCE0;
            4'd9:  pick = 14'h000;
            4'd10: pick = 14'h2284;
            4'd11: pick = 14'h228C;
            4'd12: pick = 14'h808;
            4'd13: pick = 14'h881;
            4'd14: pick = 14'h0040;
            default: pick = 14'h3FFC;
        endcase
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin : watchdog
        #(200000 * 10);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin : stimulus
        logic [15:0] lfsr;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: enables clear and route to channel 1 after reset
        ide_intrq = 2'b11;
        dma_ack   = 1'b1;
        idle(4);
        #1;
        check("R1 interrupt low after reset", 32'(irq_out), 32'd0);
        check("R1 ack routed to channel 1", 32'(ide_dmack), 32'd1);
        drive(14'h000, 1'b1, 1'b0, 8'h00);
        #1;
        check("R1 route readback", 32'(host_rdata), 32'd0);
        ide_intrq = 2'b00;
        dma_ack   = 1'b0;

        // R2: every task-file register, read and write, both channels
        for (int c = 0; c < 2; c++) begin
            for (int k = 0; k < 8; k++) begin
                ide_rdata_in = {8'(8'hB0 + k), 8'(8'h40 + k)};
                drive(14'(('h800 + c * 'h400) + k * 16), 1'b1, 1'b0, 8'h00);
                drive(14'(('h800 + c * 'h400) + k * 16), 1'b0, 1'b1, 8'(k * 17));
            end
        end
        // R3: control windows
        drive(14'h8E0, 1'b1, 1'b0, 8'h00);
        drive(14'hCE0, 1'b0, 1'b1, 8'h0A);
        idle(1);

        // R6: pending reported with enable clear
        ide_intrq = 2'b01;
        idle(2);
        drive(14'h8A4, 1'b1, 1'b0, 8'h00);
        #1;
        check("R6 status shows pending", 32'(host_rdata), 32'd1);
        check("R6 no interrupt without enable", 32'(irq_out), 32'd0);

        // R4: mask write sets enable
        drive(14'h880, 1'b0, 1'b1, 8'h00);
        idle(1);
        check("R4 enable set by mask write", 32'(irq_out), 32'd1);

        // R5: mask read clears enable
        drive(14'h880, 1'b1, 1'b0, 8'h00);
        #1;
        check("R5 mask read data", 32'(host_rdata), 32'd0);
        idle(1);
        check("R5 enable cleared by mask read", 32'(irq_out), 32'd0);

        // R7 concurrent: mask clear lands on the edge pending rises
        ide_intrq = 2'b00;
        idle(3);
        drive(14'hC80, 1'b0, 1'b1, 8'h5C);
        idle(1);
        ide_intrq = 2'b10;
        drive(14'hC80, 1'b1, 1'b0, 8'h00);
        idle(3);
        check("R7 no pulse when clear meets pending", 32'(irq_out), 32'd0);
        drive(14'hC80, 1'b0, 1'b1, 8'h00);
        idle(1);
        check("R7 interrupt from channel 2", 32'(irq_out), 32'd1);

        // R8/R9: route change while acknowledge held
        ide_dmarq = 2'b10;
        dma_ack   = 1'b1;
        drive(14'h000, 1'b0, 1'b1, 8'hFF);
        idle(1);
        check("R9 ack moved to channel 2", 32'(ide_dmack), 32'd2);
        check("R9 request from channel 2", 32'(dma_req), 32'd1);
        drive(14'h000, 1'b1, 1'b0, 8'h00);
        #1;
        check("R8 route readback", 32'(host_rdata), 32'd1);
        drive(14'h000, 1'b0, 1'b1, 8'h00);
        idle(1);
        check("R8 route restored", 32'(ide_dmack), 32'd1);
        check("R9 request from channel 1", 32'(dma_req), 32'd0);
        dma_ack = 1'b0;

        // R10: identification bits in address order
        for (int k = 0; k < 4; k++) begin
            drive(14'('h2280 + k * 4), 1'b1, 1'b0, 8'h00);
            #1;
            check("R10 ident bit", 32'(host_rdata), 32'(TYPE_CODE[k]));
        end

        // R11: undecoded accesses have no effect
        drive(14'hC80, 1'b1, 1'b0, 8'h00);
        ide_intrq = 2'b11;
        drive(14'h881, 1'b0, 1'b1, 8'hFF);
        drive(14'h808, 1'b0, 1'b1, 8'hFF);
        drive(14'h001, 1'b0, 1'b1, 8'hFF);
        drive(14'h1000, 1'b1, 1'b0, 8'h00);
        #1;
        check("R11 undecoded read", 32'(host_rdata), 32'hFF);
        idle(2);
        check("R11 no enable from undecoded write", 32'(irq_out), 32'd0);
        check("R11 route unchanged", 32'(dma_req), 32'(ide_dmarq[0]));

        // mixed pseudo-random traffic, model compared each cycle
        lfsr = 16'hACE1;
        for (int i = 0; i < 800; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (lfsr[2:0] == 3'd0) ide_intrq = lfsr[9:8];
            ide_dmarq    = lfsr[11:10];
            dma_ack      = lfsr[12];
            ide_rdata_in = {lfsr[7:0], lfsr[15:8]};
            drive(pick(lfsr[6:3]), lfsr[13] & ~lfsr[14], lfsr[14], lfsr[15:8]);
        end
        idle(2);
        finish_run();
    end

endmodule